// File: doc/BRIEF.md
# SIMT Leader-Based Memory Coalescer

This block takes one memory instruction issued by a path of a SIMT warp and turns it into a single cache-line request. Each lane supplies a word-aligned byte address, and the instruction carries a lane mask and a load/store flag. The lowest active lane becomes the leader. Every active lane whose address falls in the leader's line joins it as a follower. The leader and its followers advance to the next instruction. The remaining active lanes form a replay path that keeps the current PC.

The request leaves through a valid/ready handshake and carries an opaque tag that the memory side returns with the line. When the line comes back, a gather stage uses the tag to hand each served lane its own word from the line. If every served lane asked for the leader's word, it broadcasts the leader's word instead. For stores, each served lane's data is placed at its word position and byte enables are raised for those words only.

Top module: `simt_coalescer`

## Requirements
- R1: After reset, memReqValid and gthValid are 0 and inReady is 1.
- R2: The leader is the lowest-numbered set bit of inMask. It is always in memReqAdvance, and memReqAddr is the leader's address with its low BLK_LOG2 bits cleared.
- R3: An active lane is in memReqAdvance exactly when its address bits [ADDR_W-1:BLK_LOG2] equal the leader's.
- R4: Active lanes not in memReqAdvance are in memReqReplay. Inactive lanes are in neither mask, and the two masks never overlap.
- R5: memReqBcast is 1 exactly when every lane in memReqAdvance has the same word index (address bits [BLK_LOG2-1:2]) as the leader.
- R6: inReady equals !memReqValid || memReqReady. An accepted request appears on the memory side in the next cycle and holds all its fields stable while memReqReady is low.
- R7: A request with an all-zero mask is accepted and produces no memory request.
- R8: memReqStore echoes the store flag. On a store, line word w (bits [32w+31:32w]) carries the data of the lowest-numbered served lane whose word index is w, and byte enables [4w+3:4w] are all set for each such word and clear otherwise. On a load, every byte enable is clear.
- R9: One cycle after rspValid, gthValid is 1 and gthMask equals the served mask carried in the returned tag. Each served lane's gthData word is the returned line's word at that lane's word index, and unserved lanes read 0.
- R10: When the returned tag marks a broadcast, every served lane receives the line word at the leader's word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Instruction accepted this cycle when inValid is high |
| inMask | input | LANES | Active lanes of the path |
| inStore | input | 1 | 1 for a store, 0 for a load |
| inAddr | input | LANES*ADDR_W | Per-lane byte addresses, lane 0 in the low bits |
| inData | input | LANES*32 | Per-lane store data |
| memReqValid | output | 1 | Line request pending |
| memReqReady | input | 1 | Memory side takes the request |
| memReqAddr | output | ADDR_W | Line-aligned request address |
| memReqStore | output | 1 | Request is a store |
| memReqData | output | 8*2^BLK_LOG2 | Store line data |
| memReqBe | output | 2^BLK_LOG2 | Store byte enables |
| memReqAdvance | output | LANES | Served lanes that move to the next instruction |
| memReqReplay | output | LANES | Lanes split off to replay at the same PC |
| memReqBcast | output | 1 | All served lanes target the leader's word |
| memReqTag | output | TAG_W | Opaque tag that the memory side returns with the line |
| rspValid | input | 1 | Returned line present |
| rspTag | input | TAG_W | Tag echoed from the request |
| rspLine | input | 8*2^BLK_LOG2 | Returned line data |
| gthValid | output | 1 | Gathered words valid |
| gthMask | output | LANES | Lanes that received data |
| gthData | output | LANES*32 | Per-lane gathered words |

## Verification
Two functions can fall in the same cycle: the request side accepts a new instruction while the gather side distributes a returned line. The same cycle can also see the pending request drained and replaced. The bench runs a responder that returns queued lines at random while instructions arrive back to back with random memReqReady. This makes acceptance, stalls and gathers overlap. A behavioural model recomputes the split, the store line and the gathered words from the requirements, and every output is compared against it on every clock.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // strobes from control into the datapath
  typedef struct packed {
    logic reqLoad;   // capture a coalesced request
    logic gthLoad;   // capture gathered lane words
  } coalStrobe_t;
endpackage

// File: rtl/coal_ctrl.sv
module coal_ctrl
  import coal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        anyLane,
  input  logic        memReqReady,
  input  logic        rspValid,
  output logic        inReady,
  output logic        memReqValid,
  output logic        gthValid,
  output coalStrobe_t strobe
);
  logic accept;

  always_comb begin
    inReady        = !memReqValid || memReqReady;
    accept         = inValid && inReady;
    strobe.reqLoad = accept && anyLane;
    strobe.gthLoad = rspValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReqValid <= 1'b0;
      gthValid    <= 1'b0;
    end else begin
      if (strobe.reqLoad)   memReqValid <= 1'b1;
      else if (memReqReady) memReqValid <= 1'b0;
      gthValid <= rspValid;
    end
  end
endmodule

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES = 4,
  parameter int IDX_W = 2
) (
  input  logic [LANES-1:0] mask,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  // lowest set bit wins: scan downward so the last hit is the lowest
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_gather.sv
module coal_gather #(
  parameter int LANES  = 4,
  parameter int OFS_W  = 2,
  parameter int LINE_W = 128,
  parameter int TAG_W  = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                load,
  input  logic [TAG_W-1:0]    tag,
  input  logic [LINE_W-1:0]   line,
  output logic [LANES-1:0]    outMask,
  output logic [LANES*32-1:0] outData
);
  localparam int OFS_LSB  = LANES;
  localparam int LEAD_LSB = LANES + LANES * OFS_W;

  logic [LANES-1:0]    served;
  logic [OFS_W-1:0]    leadOfs;
  logic                bcast;
  logic [LANES*32-1:0] nxtData;

  assign served  = tag[LANES-1:0];
  assign leadOfs = tag[LEAD_LSB +: OFS_W];
  assign bcast   = tag[TAG_W-1];

  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [OFS_W-1:0] ownOfs;
    logic [OFS_W-1:0] sel;
    assign ownOfs = tag[OFS_LSB + i*OFS_W +: OFS_W];
    assign sel    = bcast ? leadOfs : ownOfs;
    assign nxtData[i*32 +: 32] = served[i] ? line[{sel, 5'b0} +: 32] : 32'd0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMask <= '0;
      outData <= '0;
    end else if (load) begin
      outMask <= served;
      outData <= nxtData;
    end
  end
endmodule

// File: rtl/coal_dp.sv
module coal_dp
  import coal_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 4,
  parameter int IDX_W    = 2,
  parameter int OFS_W    = 2,
  parameter int WORDS    = 4,
  parameter int LINE_W   = 128,
  parameter int TAG_W    = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  coalStrobe_t             strobe,
  input  logic [LANES-1:0]        inMask,
  input  logic                    inStore,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  input  logic [LANES*32-1:0]     inData,
  input  logic [TAG_W-1:0]        rspTag,
  input  logic [LINE_W-1:0]       rspLine,
  output logic                    anyLane,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic                    memReqStore,
  output logic [LINE_W-1:0]       memReqData,
  output logic [LINE_W/8-1:0]     memReqBe,
  output logic [LANES-1:0]        memReqAdvance,
  output logic [LANES-1:0]        memReqReplay,
  output logic                    memReqBcast,
  output logic [TAG_W-1:0]        memReqTag,
  output logic [LANES-1:0]        gthMask,
  output logic [LANES*32-1:0]     gthData
);
  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [OFS_W-1:0]  laneOfs  [LANES];
  logic [LANES-1:0]  served, replay, sameWord;
  logic [IDX_W-1:0]  leadIdx;
  logic [ADDR_W-1:0] leadAddr;
  logic [OFS_W-1:0]  leadOfs;
  logic              bcast;
  logic [LINE_W-1:0] lineData;
  logic [LINE_W/8-1:0] lineBe;
  logic [TAG_W-1:0]  tagNow;

  coal_leader #(.LANES(LANES), .IDX_W(IDX_W)) uLead (
    .mask(inMask), .idx(leadIdx), .found(anyLane)
  );

  assign leadAddr = laneAddr[leadIdx];
  assign leadOfs  = leadAddr[BLK_LOG2-1:2];

  for (genvar i = 0; i < LANES; i++) begin : gCmp
    logic sameBlk;
    assign laneAddr[i] = inAddr[i*ADDR_W +: ADDR_W];
    assign laneOfs[i]  = laneAddr[i][BLK_LOG2-1:2];
    assign sameBlk     = laneAddr[i][ADDR_W-1:BLK_LOG2] == leadAddr[ADDR_W-1:BLK_LOG2];
    assign served[i]   = inMask[i] && sameBlk;
    assign replay[i]   = inMask[i] && !sameBlk;
    assign sameWord[i] = !served[i] || (laneOfs[i] == leadOfs);
  end

  assign bcast = &sameWord;

  // store line: lowest served lane per word position takes the slot
  always_comb begin
    lineData = '0;
    lineBe   = '0;
    for (int w = 0; w < WORDS; w++) begin
      for (int i = LANES - 1; i >= 0; i--) begin
        if (served[i] && laneOfs[i] == OFS_W'(w)) begin
          lineData[w*32 +: 32] = inData[i*32 +: 32];
          if (inStore) lineBe[w*4 +: 4] = 4'hF;
        end
      end
    end
  end

  // tag layout: served | per-lane offsets | leader offset | broadcast
  always_comb begin
    tagNow = '0;
    tagNow[LANES-1:0] = served;
    for (int i = 0; i < LANES; i++) tagNow[LANES + i*OFS_W +: OFS_W] = laneOfs[i];
    tagNow[LANES + LANES*OFS_W +: OFS_W] = leadOfs;
    tagNow[TAG_W-1] = bcast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReqAddr    <= '0;
      memReqStore   <= 1'b0;
      memReqData    <= '0;
      memReqBe      <= '0;
      memReqAdvance <= '0;
      memReqReplay  <= '0;
      memReqBcast   <= 1'b0;
      memReqTag     <= '0;
    end else if (strobe.reqLoad) begin
      memReqAddr    <= {leadAddr[ADDR_W-1:BLK_LOG2], {BLK_LOG2{1'b0}}};
      memReqStore   <= inStore;
      memReqData    <= lineData;
      memReqBe      <= lineBe;
      memReqAdvance <= served;
      memReqReplay  <= replay;
      memReqBcast   <= bcast;
      memReqTag     <= tagNow;
    end
  end

  coal_gather #(.LANES(LANES), .OFS_W(OFS_W), .LINE_W(LINE_W), .TAG_W(TAG_W)) uGth (
    .clk(clk), .rstN(rstN), .load(strobe.gthLoad), .tag(rspTag), .line(rspLine),
    .outMask(gthMask), .outData(gthData)
  );
endmodule

// File: rtl/simt_coalescer.sv
module simt_coalescer
  import coal_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 4,
  localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int OFS_W   = BLK_LOG2 - 2,
  localparam int WORDS   = 1 << OFS_W,
  localparam int LINE_W  = 8 << BLK_LOG2,
  localparam int TAG_W   = LANES + LANES*OFS_W + OFS_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES-1:0]        inMask,
  input  logic                    inStore,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  input  logic [LANES*32-1:0]     inData,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic                    memReqStore,
  output logic [LINE_W-1:0]       memReqData,
  output logic [LINE_W/8-1:0]     memReqBe,
  output logic [LANES-1:0]        memReqAdvance,
  output logic [LANES-1:0]        memReqReplay,
  output logic                    memReqBcast,
  output logic [TAG_W-1:0]        memReqTag,
  input  logic                    rspValid,
  input  logic [TAG_W-1:0]        rspTag,
  input  logic [LINE_W-1:0]       rspLine,
  output logic                    gthValid,
  output logic [LANES-1:0]        gthMask,
  output logic [LANES*32-1:0]     gthData
);
  coalStrobe_t strobe;
  logic        anyLane;

  coal_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .anyLane(anyLane),
    .memReqReady(memReqReady), .rspValid(rspValid), .inReady(inReady),
    .memReqValid(memReqValid), .gthValid(gthValid), .strobe(strobe)
  );

  coal_dp #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .IDX_W(IDX_W),
    .OFS_W(OFS_W), .WORDS(WORDS), .LINE_W(LINE_W), .TAG_W(TAG_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inMask(inMask), .inStore(inStore),
    .inAddr(inAddr), .inData(inData), .rspTag(rspTag), .rspLine(rspLine),
    .anyLane(anyLane), .memReqAddr(memReqAddr), .memReqStore(memReqStore),
    .memReqData(memReqData), .memReqBe(memReqBe), .memReqAdvance(memReqAdvance),
    .memReqReplay(memReqReplay), .memReqBcast(memReqBcast), .memReqTag(memReqTag),
    .gthMask(gthMask), .gthData(gthData)
  );
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int LANES    = 4,
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 4,
  parameter int BE_W     = 16,
  parameter int TAG_W    = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memReqStore,
  input logic [BE_W-1:0]   memReqBe,
  input logic [LANES-1:0]  memReqAdvance,
  input logic [LANES-1:0]  memReqReplay,
  input logic              memReqBcast,
  input logic              rspValid,
  input logic [TAG_W-1:0]  rspTag,
  input logic              gthValid,
  input logic [LANES-1:0]  gthMask
);
  logic [LANES-1:0] allAct, lowBit;
  assign allAct = memReqAdvance | memReqReplay;
  assign lowBit = allAct & (~allAct + 1'b1);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) &&
      $stable(memReqAdvance) && $stable(memReqReplay)); // R6
  AST_SPLIT_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAdvance & memReqReplay) == '0); // R4
  AST_LEADER_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (lowBit & memReqAdvance) != '0); // R2
  AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[BLK_LOG2-1:0] == '0); // R2
  AST_LOAD_NO_BE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqStore |-> memReqBe == '0); // R8
  AST_BCAST_ONE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqStore && memReqBcast |-> $countones(memReqBe) == 4); // R5
  AST_GTH_MASK: assert property (@(posedge clk) disable iff (!rstN)
    gthValid |-> $past(rspValid) && gthMask == $past(rspTag[LANES-1:0])); // R9
endmodule

bind simt_coalescer coal_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .BE_W(LINE_W/8), .TAG_W(TAG_W)
) uChk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .memReqStore(memReqStore), .memReqBe(memReqBe),
  .memReqAdvance(memReqAdvance), .memReqReplay(memReqReplay), .memReqBcast(memReqBcast),
  .rspValid(rspValid), .rspTag(rspTag), .gthValid(gthValid), .gthMask(gthMask)
);

// File: tb/sim_simt_coalescer.sv
`timescale 1ns/1ps
module sim_simt_coalescer;
  localparam int L = 4;
  localparam int AW = 32;
  localparam int LW = 128;
  localparam int TW = 15;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inStore = 1'b0, memReqReady = 1'b0, rspValid = 1'b0;
  logic [L-1:0] inMask = '0;
  logic [L*AW-1:0] inAddr = '0;
  logic [L*32-1:0] inData = '0;
  logic [TW-1:0] rspTag = '0;
  logic [LW-1:0] rspLine = '0;
  logic inReady, memReqValid, memReqStore, memReqBcast, gthValid;
  logic [AW-1:0] memReqAddr;
  logic [LW-1:0] memReqData;
  logic [LW/8-1:0] memReqBe;
  logic [L-1:0] memReqAdvance, memReqReplay, gthMask;
  logic [TW-1:0] memReqTag;
  logic [L*32-1:0] gthData;

  simt_coalescer u0 (.*);

  always #2 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic mValid = 0, mStore = 0, mBc = 0, mGthValid = 0;
  logic [31:0] mAddr = 0;
  logic [L-1:0] mAdv = 0, mRep = 0, mGthMask = 0;
  logic [LW-1:0] mData = 0;
  logic [LW/8-1:0] mBe = 0;
  logic [7:0] mOfs = 0;
  logic [L*32-1:0] mGthData = 0;
  logic [TW-1:0] seenTag = 0;
  // outstanding line requests
  logic [31:0] qAddr[$];
  logic [L-1:0] qAdv[$];
  logic [7:0] qOfs[$];
  logic qBc[$];
  logic [TW-1:0] qTag[$];
  // response being driven
  logic [31:0] cAddr = 0;
  logic [L-1:0] cAdv = 0;
  logic [7:0] cOfs = 0;
  logic cBc = 0;

  function automatic logic [31:0] lineWord(logic [31:0] a, int w);
    return ((a & 32'hFFFF_FFF0) ^ 32'h5A5A_0000) + 32'h0101_0101 * w;
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic makeReq(int kind);
    logic [31:0] blk = $urandom & 32'hFFFF_FFF0;
    int w0 = $urandom % 4;
    for (int i = 0; i < L; i++) begin
      case (kind)
        0: inAddr[i*32 +: 32] = blk + 32'(w0 * 4);
        1: inAddr[i*32 +: 32] = blk + 32'(i * 4);
        default: inAddr[i*32 +: 32] = blk + 32'(16 * ($urandom % 3)) + 32'(4 * ($urandom % 4));
      endcase
      inData[i*32 +: 32] = $urandom;
    end
    inMask = ($urandom % 2) ? 4'hF : 4'($urandom % 16);
    if (kind == 3) inMask = '0;
    else if (inMask == '0) inMask = 4'b0100;
    inStore = $urandom % 2;
    inValid = ($urandom % 10) < 8;
  endtask

  task automatic modelEdge();
    logic acc;
    int lead;
    logic [31:0] la, ad;
    logic found;
    if (mValid && memReqReady) begin
      qAddr.push_back(mAddr); qAdv.push_back(mAdv); qOfs.push_back(mOfs);
      qBc.push_back(mBc); qTag.push_back(seenTag);
    end
    mGthValid = rspValid;
    if (rspValid) begin
      mGthMask = cAdv;
      for (int i = 0; i < L; i++)
        mGthData[i*32 +: 32] = cAdv[i] ? lineWord(cAddr, int'((cOfs >> (2*i)) & 8'd3)) : 32'd0;
    end
    acc = inValid && (!mValid || memReqReady);
    if (acc && inMask != 0) begin
      lead = -1;
      for (int i = 0; i < L; i++) if (inMask[i] && lead < 0) lead = i;
      la = inAddr[lead*32 +: 32];
      mAdv = 0; mRep = 0; mBc = 1; mOfs = 0;
      for (int i = 0; i < L; i++) begin
        ad = inAddr[i*32 +: 32];
        mOfs[2*i +: 2] = ad[3:2];
        if (inMask[i]) begin
          if (ad[31:4] == la[31:4]) mAdv[i] = 1; else mRep[i] = 1;
        end
        if (mAdv[i] && ad[3:2] != la[3:2]) mBc = 0;
      end
      mData = 0; mBe = 0;
      for (int w = 0; w < 4; w++) begin
        found = 0;
        for (int i = 0; i < L; i++) begin
          ad = inAddr[i*32 +: 32];
          if (!found && mAdv[i] && int'(ad[3:2]) == w) begin
            mData[w*32 +: 32] = inData[i*32 +: 32];
            found = 1;
          end
        end
        if (found && inStore) mBe[w*4 +: 4] = 4'hF;
      end
      mAddr = la & 32'hFFFF_FFF0;
      mStore = inStore;
      mValid = 1;
    end else if (memReqReady) mValid = 0;
  endtask

  task automatic compare();
    chk("R6/R7", "memReqValid", 128'(memReqValid), 128'(mValid));
    if (mValid) begin
      chk("R2", "memReqAddr", 128'(memReqAddr), 128'(mAddr));
      chk("R3", "memReqAdvance", 128'(memReqAdvance), 128'(mAdv));
      chk("R4", "memReqReplay", 128'(memReqReplay), 128'(mRep));
      chk("R5", "memReqBcast", 128'(memReqBcast), 128'(mBc));
      chk("R8", "memReqStore", 128'(memReqStore), 128'(mStore));
      chk("R8", "memReqBe", 128'(memReqBe), 128'(mBe));
      if (mStore) chk("R8", "memReqData", memReqData & 128'(0) | (memReqData), mData);
    end
    chk("R9", "gthValid", 128'(gthValid), 128'(mGthValid));
    if (mGthValid) begin
      chk("R9", "gthMask", 128'(gthMask), 128'(mGthMask));
      if (cBcLast) chk("R10", "gthData", 128'(gthData), 128'(mGthData));
      else chk("R9", "gthData", 128'(gthData), 128'(mGthData));
    end
  endtask

  logic cBcLast = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "memReqValid", 128'(memReqValid), 128'd0);
    chk("R1", "gthValid", 128'(gthValid), 128'd0);
    chk("R1", "inReady", 128'(inReady), 128'd1);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      cBcLast = cBc;
      modelEdge();
      compare();
      seenTag = memReqTag;
      // new stimulus
      begin
        int r = $urandom % 10;
        int kind = (cyc < 40) ? cyc % 4 : (r < 3 ? 0 : r < 6 ? 1 : r < 9 ? 2 : 3);
        makeReq(kind);
      end
      memReqReady = (cyc < 40) ? (cyc % 3 != 2) : (($urandom % 10) < 7);
      if (qAddr.size() > 0 && ($urandom % 10) < 6) begin
        cAddr = qAddr.pop_front(); cAdv = qAdv.pop_front(); cOfs = qOfs.pop_front();
        cBc = qBc.pop_front(); rspTag = qTag.pop_front();
        for (int w = 0; w < 4; w++) rspLine[w*32 +: 32] = lineWord(cAddr, w);
        rspValid = 1'b1;
      end else rspValid = 1'b0;
      #1;
      chk("R6", "inReady", 128'(inReady), 128'(!mValid || memReqReady));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule